// File: doc/BRIEF.md
# Configurable Pixel Serializer

The serializer takes 32-bit memory words from a pixel FIFO and turns them into a stream of pixels, one per accepted output handshake. A format code selects a pixel width of 1, 2, 4, 8, 16 or 24 bits. A separate control selects which end of each word the first pixel comes from. At 24 bits per pixel the words can be read either packed, with pixels laid back to back across word boundaries, or unpacked, with a single pixel in the low three bytes of every word.

A bit buffer holds whatever part of the fetched words has not yet been emitted. A new word is pulled from the FIFO only when the remaining bits cannot form the next whole pixel. Because of this, output stalls never consume input. Pixels leave on a valid/ready interface, right-aligned on a 24-bit bus. The configuration inputs are meant to be static while data flows, and are changed only while reset is held.

Top module: `pixel_serializer`

## Requirements
- R1: `fmt_i` selects the pixel width: 0 gives 1 bit, 1 gives 2, 2 gives 4, 3 gives 8, 4 gives 16 and 5 gives 24 bits, while codes 6 and 7 act as 8 bits. A pixel narrower than 24 bits sits in the low bits of `pix_o`, and all higher bits of `pix_o` are zero.
- R2: With `msb_first_i` = 0, pixels leave each word starting at bit 0 and moving upward. Each pixel's least significant bit is the lowest bit it occupies.
- R3: With `msb_first_i` = 1, pixels leave each word starting at bit 31 and moving downward. Each pixel's most significant bit is the highest bit it occupies.
- R4: With `fmt_i` = 5 and `pack24_i` = 1, pixels are read back to back with no padding, so a pixel may take bits from two consecutive words. Every three words yield four pixels, and at most 16 unused bits remain when the next word is taken.
- R5: With `fmt_i` = 5 and `pack24_i` = 0, each word yields exactly one pixel, taken from bits 23:0. Bits 31:24 have no effect on any output.
- R6: `word_ready_o` is high exactly when the buffered bits are fewer than one pixel width. A word is consumed only on a cycle with `word_valid_i` and `word_ready_o` both high.
- R7: `pix_valid_o` is high exactly when at least one whole pixel is buffered. While `pix_valid_o` is high and `pix_ready_i` is low, `pix_o` stays unchanged and no word is taken from the FIFO.
- R8: After reset the buffer is empty, so `pix_valid_o` is 0 and `word_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| fmt_i | input | 3 | Pixel width code (see R1) |
| pack24_i | input | 1 | 1 selects the packed 24-bit layout |
| msb_first_i | input | 1 | 1 emits pixels from the top of the word first |
| word_valid_i | input | 1 | FIFO holds a word |
| word_i | input | 32 | FIFO head word |
| word_ready_o | output | 1 | Word is taken this cycle if valid |
| pix_valid_o | output | 1 | A pixel is presented |
| pix_ready_i | input | 1 | Consumer accepts the pixel |
| pix_o | output | 24 | Right-aligned pixel value |

## Verification
Both handshake outputs and the pixel value depend only on the buffer state. A word accepted at a rising edge therefore makes its first pixel visible straight after that edge, and a pixel taken at an edge exposes the next pixel, or raises `word_ready_o`, straight after that same edge. The bench drives inputs and compares at the falling edge. Before each edge, its queue-of-bits model applies the handshakes that the edge will fire, so every comparison falls in the first cycle a result is due. Stall cycles are additionally compared against the pixel shown on the cycle before.

// File: rtl/ps_pkg.sv
package ps_pkg;

  typedef enum logic [2:0] {
    PX_W1  = 3'd0,
    PX_W2  = 3'd1,
    PX_W4  = 3'd2,
    PX_W8  = 3'd3,
    PX_W16 = 3'd4,
    PX_W24 = 3'd5
  } px_fmt_e;

  // Width in bits of one pixel for a format code; spare codes behave as 8 bits.
  function automatic int unsigned px_width(logic [2:0] code);
    case (px_fmt_e'(code))
      PX_W1:   return 1;
      PX_W2:   return 2;
      PX_W4:   return 4;
      PX_W8:   return 8;
      PX_W16:  return 16;
      PX_W24:  return 24;
      default: return 8;
    endcase
  endfunction

  // Bits contributed to the stream by one fetched word.
  function automatic int unsigned chunk_bits(logic [2:0] code, logic packed24);
    return (code == 3'(PX_W24) && !packed24) ? 24 : 32;
  endfunction

endpackage

// File: rtl/ps_width_dec.sv
module ps_width_dec #(
  parameter int CNT_W = 6
) (
  input  logic [2:0]       fmt_i,
  input  logic             pack24_i,
  output logic [CNT_W-1:0] width_o,
  output logic [CNT_W-1:0] chunk_o,
  output logic             one_per_word_o
);
  always_comb begin
    width_o        = CNT_W'(ps_pkg::px_width(fmt_i));
    chunk_o        = CNT_W'(ps_pkg::chunk_bits(fmt_i, pack24_i));
    one_per_word_o = (fmt_i == 3'(ps_pkg::PX_W24)) && !pack24_i;
  end
endmodule

// File: rtl/ps_bitbuf.sv
module ps_bitbuf #(
  parameter int WORD_W  = 32,
  parameter int PIX_MAX = 24,
  parameter int BUF_W   = 56,
  parameter int CNT_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msb_first_i,
  input  logic              one_per_word_i,
  input  logic [CNT_W-1:0]  width_i,
  input  logic [CNT_W-1:0]  chunk_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              load_i,
  input  logic              take_i,
  output logic [BUF_W-1:0]  bits_o,
  output logic [CNT_W-1:0]  fill_o
);
  logic [BUF_W-1:0] bits_q;
  logic [CNT_W-1:0] fill_q;
  logic [BUF_W-1:0] chunk;
  logic [CNT_W-1:0] top_shift;

  // Stream order: low end first when LSB-first, high end first otherwise.
  always_comb begin
    chunk     = one_per_word_i ? BUF_W'(word_i[PIX_MAX-1:0]) : BUF_W'(word_i);
    top_shift = CNT_W'(BUF_W) - chunk_i - fill_q;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      bits_q <= '0;
      fill_q <= '0;
    end else if (load_i) begin
      bits_q <= bits_q | (msb_first_i ? (chunk << top_shift) : (chunk << fill_q));
      fill_q <= fill_q + chunk_i;
    end else if (take_i) begin
      bits_q <= msb_first_i ? (bits_q << width_i) : (bits_q >> width_i);
      fill_q <= fill_q - width_i;
    end
  end

  assign bits_o = bits_q;
  assign fill_o = fill_q;
endmodule

// File: rtl/ps_extract.sv
module ps_extract #(
  parameter int PIX_MAX = 24,
  parameter int BUF_W   = 56,
  parameter int CNT_W   = 6
) (
  input  logic [BUF_W-1:0]   bits_i,
  input  logic [CNT_W-1:0]   width_i,
  input  logic               msb_first_i,
  output logic [PIX_MAX-1:0] pix_o
);
  logic [BUF_W-1:0]   aligned;
  logic [PIX_MAX-1:0] keep;

  always_comb begin
    aligned = msb_first_i ? (bits_i >> (CNT_W'(BUF_W) - width_i)) : bits_i;
    keep    = ~({PIX_MAX{1'b1}} << width_i);
    pix_o   = PIX_MAX'(aligned) & keep;
  end
endmodule

// File: rtl/pixel_serializer.sv
module pixel_serializer #(
  parameter int WORD_W  = 32,
  parameter int PIX_MAX = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         fmt_i,
  input  logic               pack24_i,
  input  logic               msb_first_i,
  input  logic               word_valid_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic               word_ready_o,
  output logic               pix_valid_o,
  input  logic               pix_ready_i,
  output logic [PIX_MAX-1:0] pix_o
);
  localparam int BUF_W = WORD_W + PIX_MAX;
  localparam int CNT_W = $clog2(BUF_W + 1);

  logic [CNT_W-1:0] width;
  logic [CNT_W-1:0] chunk;
  logic             one_per_word;
  logic [BUF_W-1:0] bits;
  logic [CNT_W-1:0] fill;
  logic             load_evt;
  logic             take_evt;

  ps_width_dec #(.CNT_W(CNT_W)) u_dec (
    .fmt_i(fmt_i), .pack24_i(pack24_i),
    .width_o(width), .chunk_o(chunk), .one_per_word_o(one_per_word)
  );

  assign pix_valid_o  = fill >= width;
  assign word_ready_o = fill < width;
  assign load_evt     = word_valid_i && word_ready_o;
  assign take_evt     = pix_valid_o && pix_ready_i;

  ps_bitbuf #(.WORD_W(WORD_W), .PIX_MAX(PIX_MAX), .BUF_W(BUF_W), .CNT_W(CNT_W)) u_buf (
    .clk_i(clk_i), .rst_ni(rst_ni), .msb_first_i(msb_first_i),
    .one_per_word_i(one_per_word), .width_i(width), .chunk_i(chunk),
    .word_i(word_i), .load_i(load_evt), .take_i(take_evt),
    .bits_o(bits), .fill_o(fill)
  );

  ps_extract #(.PIX_MAX(PIX_MAX), .BUF_W(BUF_W), .CNT_W(CNT_W)) u_ext (
    .bits_i(bits), .width_i(width), .msb_first_i(msb_first_i), .pix_o(pix_o)
  );
endmodule

// File: rtl/ps_checker.sv
module ps_checker #(
  parameter int PIX_MAX = 24,
  parameter int CNT_W   = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [2:0]         fmt_i,
  input logic               pack24_i,
  input logic               word_ready_o,
  input logic               pix_valid_o,
  input logic               pix_ready_i,
  input logic [PIX_MAX-1:0] pix_o,
  input logic               load_evt,
  input logic               take_evt,
  input logic [CNT_W-1:0]   fill
);
  // R7: a stalled pixel is held unchanged on the next cycle
  a_r7_hold_pixel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && !pix_ready_i) |=> (pix_valid_o && $stable(pix_o)));

  // R7: no FIFO word is taken while a pixel waits
  a_r7_no_fetch_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && !pix_ready_i) |-> !load_evt);

  // R4: leftover before a new word in packed mode never exceeds 16 bits
  a_r4_leftover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_evt && pack24_i && fmt_i == 3'd5) |-> (fill <= CNT_W'(16)));

  // R1: narrow pixels leave the upper bus bits at zero
  a_r1_zero_8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && fmt_i == 3'd3) |-> (pix_o[PIX_MAX-1:8] == '0));
  a_r1_zero_1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && fmt_i == 3'd0) |-> (pix_o[PIX_MAX-1:1] == '0));

  // R6: a word is taken only while the buffer lacks a whole pixel
  a_r6_one_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_evt |-> (word_ready_o && !take_evt));
endmodule

bind pixel_serializer ps_checker #(.PIX_MAX(PIX_MAX), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fmt_i(fmt_i), .pack24_i(pack24_i),
  .word_ready_o(word_ready_o), .pix_valid_o(pix_valid_o), .pix_ready_i(pix_ready_i),
  .pix_o(pix_o), .load_evt(load_evt), .take_evt(take_evt), .fill(fill)
);

// File: tb/pixel_serializer_test.sv
module pixel_serializer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  fmt_i = 3'd0;
  logic        pack24_i = 1'b0;
  logic        msb_first_i = 1'b0;
  logic        word_valid_i = 1'b0;
  logic [31:0] word_i = '0;
  logic        word_ready_o;
  logic        pix_valid_o;
  logic        pix_ready_i = 1'b0;
  logic [23:0] pix_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  pixel_serializer uut (.*);

  always #5 clk_i = ~clk_i;

  bit q[$];

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic int model_w(logic [2:0] f);
    if (f <= 3'd4) return 1 << f;
    if (f == 3'd5) return 24;
    return 8;
  endfunction

  // value of the first n stream bits, ordered by the selected direction
  function automatic logic [31:0] head_value(int n, bit msb);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) begin
      if (msb) v = {v[30:0], q[i]};
      else     v[i] = q[i];
    end
    return v;
  endfunction

  task automatic push_word(logic [31:0] wd);
    int n = (fmt_i == 3'd5 && !pack24_i) ? 24 : 32;
    for (int i = 0; i < n; i++) q.push_back(msb_first_i ? wd[n-1-i] : wd[i]);
  endtask

  task automatic run_cfg(logic [2:0] f, bit pk, bit msb, int cycles, int vpct, int rpct);
    int w;
    bit prev_stall = 0;
    logic [23:0] prev_pix = '0;
    string tag;
    @(negedge clk_i);
    rst_ni = 1'b0; word_valid_i = 1'b0; pix_ready_i = 1'b0;
    fmt_i = f; pack24_i = pk; msb_first_i = msb;
    q.delete();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(pix_valid_o == 1'b0, "R8 pix_valid after reset", 32'(pix_valid_o), 32'd0);
    chk(word_ready_o == 1'b1, "R8 word_ready after reset", 32'(word_ready_o), 32'd1);
    w = model_w(f);
    if (f == 3'd5) tag = pk ? "R4 packed pixel" : "R5 unpacked pixel";
    else tag = msb ? "R3 msb-first pixel" : "R2 lsb-first pixel";
    for (int c = 0; c < cycles; c++) begin
      bit ev = (q.size() >= w);
      bit er = (q.size() < w);
      logic [31:0] ex;
      chk(word_ready_o == er, "R6 word_ready", 32'(word_ready_o), 32'(er));
      chk(pix_valid_o == ev, "R7 pix_valid", 32'(pix_valid_o), 32'(ev));
      if (ev) begin
        ex = head_value(w, msb);
        chk({8'd0, pix_o} == ex, tag, {8'd0, pix_o}, ex);
        if (w < 24)
          chk((pix_o >> w) == 24'd0, "R1 upper bits zero", {8'd0, pix_o}, ex);
        if (prev_stall)
          chk(pix_o == prev_pix, "R7 stalled pixel held", {8'd0, pix_o}, {8'd0, prev_pix});
      end
      word_valid_i = ($urandom % 100) < vpct;
      word_i = $urandom;
      pix_ready_i = ($urandom % 100) < rpct;
      prev_stall = ev && !pix_ready_i;
      prev_pix = pix_o;
      if (word_valid_i && er) push_word(word_i);
      if (ev && pix_ready_i) for (int i = 0; i < w; i++) void'(q.pop_front());
      @(negedge clk_i);
    end
  endtask

  initial begin
    for (int m = 0; m < 2; m++) begin
      for (int f = 0; f < 5; f++) run_cfg(3'(f), 1'b0, m[0], 250, 70, 60);
      run_cfg(3'd5, 1'b1, m[0], 300, 70, 60);
      run_cfg(3'd5, 1'b0, m[0], 200, 70, 60);
      run_cfg(3'd5, 1'b1, m[0], 120, 100, 100);
    end
    run_cfg(3'd7, 1'b0, 1'b0, 150, 60, 60);  // R1 spare code as 8 bits
    run_cfg(3'd6, 1'b1, 1'b1, 150, 60, 60);  // R1 spare code as 8 bits
    run_cfg(3'd2, 1'b0, 1'b1, 150, 100, 20); // R7 heavy output stall
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule